// File: doc/BRIEF.md
# Power-up reset timing sequencer

This block holds a device-wide reset asserted while a fixed chain of start-up delays runs, and releases it only when every delay that applies has finished. The first delay is a power-up wait that counts slow internal RC ticks. The second is a crystal settling wait that counts main oscillator cycles, and it runs only for crystal oscillator modes. The third is a PLL lock wait in RC ticks, and it runs only in the crystal-with-PLL mode. The block also filters a digital low-supply flag. A dip that lasts long enough forces a brown-out hold, and leaving the hold runs the power-up wait again.

Both time bases arrive as single-cycle enable pulses in the sequencer clock domain. `rc_tick` marks one RC period and `osc_tick` marks one main oscillator cycle. A power-on pulse restarts the whole chain from any state. A wake request issued while running re-enters the crystal settling wait when the oscillator mode needs one. The current step is reported as a 3-bit code, and a done flag is high only in the running state.

Top module: `pwrup_seq`

## Requirements
- R1: When `rst_n` is low, or when `por_pulse` is high at a clock edge, the state code is IDLE (0) after that edge. `por_pulse` takes priority over every other input and leaves any state. After a power-on pulse ends, the full chain runs again.
- R2: The state codes are IDLE=0, power-up wait=1, crystal wait=2, lock wait=3, brown-out hold=4 and RUN=5. No other code ever appears. `seq_done` is 1 only in RUN, and `dev_reset` is its inverse.
- R3: With `pwrup_en_n`=0, the sequencer stays in the power-up wait for exactly 2^PWRUP_BITS `rc_tick` pulses. With `pwrup_en_n`=1 the power-up wait is skipped.
- R4: `osc_mode` codes 0, 1, 2 and 3 are crystal modes, and codes 4 to 7 are not. After a power-on start in a crystal mode, the crystal wait lasts exactly XTAL_CYCLES `osc_tick` pulses. In the other modes it is skipped.
- R5: Only in mode 3, the lock wait of exactly LOCK_TICKS `rc_tick` pulses follows the crystal wait, and then RUN is entered. The lock wait is entered only from the crystal wait.
- R6: A `wake_req` pulse in RUN with a crystal mode enters the crystal wait, followed by the lock wait in mode 3. With a non-crystal mode the request is ignored and the state stays RUN.
- R7: With `brown_en`=1 in the crystal wait, the lock wait or RUN, a `brown_low` flag held for BROWN_FILTER RC ticks or fewer is ignored. A flag still high at the next tick forces the brown-out hold.
- R8: With `brown_en`=0, `brown_low` has no effect.
- R9: The brown-out hold lasts for as long as `brown_low` stays high.
- R10: Leaving the brown-out hold with `pwrup_en_n`=0 runs the full power-up wait and then enters RUN. The crystal wait and the lock wait are skipped.
- R11: A `brown_low` flag, with `brown_en`=1, during the power-up wait returns the sequencer to the brown-out hold at the next edge, with no filtering. The next power-up wait counts its full length again.
- R12: Leaving the brown-out hold with `pwrup_en_n`=1 enters RUN at the next edge. Enabling brown-out detection does not enable the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_pulse | input | 1 | Power-on reset pulse, highest priority |
| brown_low | input | 1 | Digital low-supply comparator flag |
| rc_tick | input | 1 | One-cycle pulse per internal RC period |
| osc_tick | input | 1 | One-cycle pulse per main oscillator cycle |
| osc_mode | input | 3 | Oscillator mode code (0-3 crystal, 3 with PLL) |
| pwrup_en_n | input | 1 | Power-up wait enable, active low |
| brown_en | input | 1 | Brown-out detection enable |
| wake_req | input | 1 | Wake from a low-power mode |
| dev_reset | output | 1 | Device reset, high until RUN |
| seq_state | output | 3 | Current sequencer state code |
| seq_done | output | 1 | High only in RUN |

## Verification
The bench sweeps every oscillator mode against both power-up enable settings and two tick rates, and counts the ticks spent in each wait against 2^PWRUP_BITS, XTAL_CYCLES and LOCK_TICKS. An off-by-one counter, or a stage that runs in the wrong mode, shows up as a tick count that does not match. It probes the filter edge with dips of exactly BROWN_FILTER and BROWN_FILTER+1 ticks. A filter that trips early resets on a harmless dip, and one that trips late never enters the hold. A flag that returns mid-way through the power-up wait must restart the full count, which catches a counter that resumes instead of reloading. Further tests cover exits from the hold with the power-up wait disabled, a power-on pulse issued mid-wait, and wake requests in crystal and non-crystal modes. These find a crystal wait run after a brown-out, a wake that is lost, or a pulse that fails to pre-empt a stage.

// File: rtl/pwrup_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-up sequencer: state codes and mode helpers.
// Assumes the 3-bit state code is visible at the block edge unchanged.
package pwrup_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PWRUP = 3'd1,
        ST_XTAL  = 3'd2,
        ST_LOCK  = 3'd3,
        ST_BROWN = 3'd4,
        ST_RUN   = 3'd5
    } seq_state_e;

    localparam logic [2:0] MODE_XTAL_PLL = 3'd3;

    // Crystal modes (codes 0 to 3) need the oscillator settling wait.
    function automatic logic needs_xtal(input logic [2:0] mode);
        return mode <= MODE_XTAL_PLL;
    endfunction

    // Only the crystal-with-PLL mode needs the lock wait.
    function automatic logic needs_lock(input logic [2:0] mode);
        return mode == MODE_XTAL_PLL;
    endfunction

endpackage

// File: rtl/brown_filter.sv
`timescale 1ns/1ps
// Glitch filter for the low-supply flag.
// Counts RC ticks while the enabled flag stays high and clears when it drops.
// Trips on the tick after FILTER ticks have been counted.
// Assumes rc_tick is a one-cycle pulse in the clk domain.
module brown_filter #(
    parameter int FILTER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic brown_en,
    input  logic brown_low,
    input  logic rc_tick,
    output logic brown_now,
    output logic brown_trip
);

    assign brown_now = brown_en & brown_low;

    generate
        if (FILTER == 0) begin : g_nofilt
            assign brown_trip = brown_now & rc_tick;
        end else begin : g_filt
            localparam int FW = $clog2(FILTER + 1);
            localparam logic [FW-1:0] LIMIT = FW'(FILTER);
            logic [FW-1:0] dwell;

            // Saturating count of RC ticks spent with the flag high.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dwell <= '0;
                else if (!brown_now)
                    dwell <= '0;
                else if (rc_tick && dwell != LIMIT)
                    dwell <= dwell + 1'b1;
            end

            assign brown_trip = brown_now & rc_tick & (dwell == LIMIT);
        end
    endgenerate

endmodule

// File: rtl/stage_timer.sv
`timescale 1ns/1ps
// Single counter shared by all wait stages.
// The sequencer clears it on each state change. It counts step pulses and
// flags the step that completes 'limit' steps. Assumes limit >= 1.
module stage_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic [TW-1:0] count;

    // Step counter with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end

    assign expire = step && (count == limit - 1'b1);

endmodule

// File: rtl/pwrup_fsm.sv
`timescale 1ns/1ps
// Sequencer state machine: power-up wait, crystal wait, lock wait, run,
// and the brown-out hold. Remembers whether the current start may run the
// crystal wait (power-on or wake) or not (brown-out exit).
// Assumes stage_done comes from a timer that it clears via stage_clr.
module pwrup_fsm
    import pwrup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_pulse,
    input  logic       brown_now,
    input  logic       brown_trip,
    input  logic       stage_done,
    input  logic [2:0] osc_mode,
    input  logic       pwrup_en_n,
    input  logic       wake_req,
    output seq_state_e state,
    output logic       stage_clr
);

    seq_state_e nxt;
    logic       xtal_ok, nxt_xtal_ok;

    // Stage that follows the power-up wait (or stands in for it).
    function automatic seq_state_e after_pwrup(input logic ok, input logic [2:0] mode);
        return (ok && needs_xtal(mode)) ? ST_XTAL : ST_RUN;
    endfunction

    // Next-state and start-cause decision.
    always_comb begin
        nxt         = state;
        nxt_xtal_ok = xtal_ok;
        case (state)
            ST_IDLE: begin
                nxt_xtal_ok = 1'b1;
                nxt = pwrup_en_n ? after_pwrup(1'b1, osc_mode) : ST_PWRUP;
            end
            ST_PWRUP: begin
                if (brown_now)
                    nxt = ST_BROWN;
                else if (stage_done)
                    nxt = after_pwrup(xtal_ok, osc_mode);
            end
            ST_XTAL: begin
                if (brown_trip)
                    nxt = ST_BROWN;
                else if (stage_done)
                    nxt = needs_lock(osc_mode) ? ST_LOCK : ST_RUN;
            end
            ST_LOCK: begin
                if (brown_trip)
                    nxt = ST_BROWN;
                else if (stage_done)
                    nxt = ST_RUN;
            end
            ST_RUN: begin
                if (brown_trip)
                    nxt = ST_BROWN;
                else if (wake_req && needs_xtal(osc_mode)) begin
                    nxt         = ST_XTAL;
                    nxt_xtal_ok = 1'b1;
                end
            end
            ST_BROWN: begin
                if (!brown_now)
                    nxt = pwrup_en_n ? after_pwrup(1'b0, osc_mode) : ST_PWRUP;
            end
            default: nxt = ST_IDLE;
        endcase
        if (nxt == ST_BROWN)
            nxt_xtal_ok = 1'b0;
        if (por_pulse) begin
            nxt         = ST_IDLE;
            nxt_xtal_ok = 1'b1;
        end
    end

    // State and start-cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            xtal_ok <= 1'b1;
        end else begin
            state   <= nxt;
            xtal_ok <= nxt_xtal_ok;
        end
    end

    assign stage_clr = por_pulse || (nxt != state);

endmodule

// File: rtl/pwrup_seq.sv
`timescale 1ns/1ps
// Power-up reset timing sequencer top.
// Holds dev_reset until the power-up, crystal and lock waits that apply
// have completed, and filters the low-supply flag into a brown-out hold.
// Assumes rc_tick and osc_tick are one-cycle enables synchronous to clk.
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int PWRUP_BITS   = 11,
    parameter int XTAL_CYCLES  = 1024,
    parameter int LOCK_TICKS   = 63,
    parameter int BROWN_FILTER = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_pulse,
    input  logic       brown_low,
    input  logic       rc_tick,
    input  logic       osc_tick,
    input  logic [2:0] osc_mode,
    input  logic       pwrup_en_n,
    input  logic       brown_en,
    input  logic       wake_req,
    output logic       dev_reset,
    output logic [2:0] seq_state,
    output logic       seq_done
);

    localparam int PW  = PWRUP_BITS + 1;
    localparam int XW  = $clog2(XTAL_CYCLES + 1);
    localparam int LW  = $clog2(LOCK_TICKS + 1);
    localparam int PXW = (PW > XW) ? PW : XW;
    localparam int TW  = (PXW > LW) ? PXW : LW;

    seq_state_e    fsm_state;
    logic          brown_now, brown_trip;
    logic          stage_clr, stage_done, stage_step;
    logic [TW-1:0] stage_limit;

    brown_filter #(.FILTER(BROWN_FILTER)) i_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .brown_en   (brown_en),
        .brown_low  (brown_low),
        .rc_tick    (rc_tick),
        .brown_now  (brown_now),
        .brown_trip (brown_trip)
    );

    // Pick the time base and length for the active wait stage.
    always_comb begin
        stage_step  = 1'b0;
        stage_limit = TW'(1);
        case (fsm_state)
            ST_PWRUP: begin
                stage_step  = rc_tick;
                stage_limit = TW'(1) << PWRUP_BITS;
            end
            ST_XTAL: begin
                stage_step  = osc_tick;
                stage_limit = TW'(XTAL_CYCLES);
            end
            ST_LOCK: begin
                stage_step  = rc_tick;
                stage_limit = TW'(LOCK_TICKS);
            end
            default: ;
        endcase
    end

    stage_timer #(.TW(TW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (stage_clr),
        .step   (stage_step),
        .limit  (stage_limit),
        .expire (stage_done)
    );

    pwrup_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_pulse  (por_pulse),
        .brown_now  (brown_now),
        .brown_trip (brown_trip),
        .stage_done (stage_done),
        .osc_mode   (osc_mode),
        .pwrup_en_n (pwrup_en_n),
        .wake_req   (wake_req),
        .state      (fsm_state),
        .stage_clr  (stage_clr)
    );

    assign seq_state = fsm_state;
    assign seq_done  = (fsm_state == ST_RUN);
    assign dev_reset = (fsm_state != ST_RUN);

endmodule

// File: rtl/pwrup_seq_chk.sv
`timescale 1ns/1ps
// Property checker for pwrup_seq, attached by bind.
// Observes only the block's ports.
module pwrup_seq_chk
    import pwrup_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       por_pulse,
    input logic       brown_low,
    input logic       brown_en,
    input logic       pwrup_en_n,
    input logic       wake_req,
    input logic [2:0] seq_state
);

    assert_por_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |=> seq_state == ST_IDLE);

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state <= ST_RUN);

    assert_lock_after_xtal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_LOCK) |-> ($past(seq_state) == ST_XTAL || $past(seq_state) == ST_LOCK));

    assert_brown_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!brown_en && seq_state == ST_RUN && !por_pulse && !wake_req) |=> seq_state == ST_RUN);

    assert_hold_while_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_BROWN && brown_en && brown_low && !por_pulse) |=> seq_state == ST_BROWN);

    assert_pwrup_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_PWRUP && brown_en && brown_low && !por_pulse) |=> seq_state == ST_BROWN);

    assert_exit_direct_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_BROWN && !(brown_en && brown_low) && pwrup_en_n && !por_pulse)
        |=> seq_state == ST_RUN);

endmodule

bind pwrup_seq pwrup_seq_chk i_pwrup_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_pulse  (por_pulse),
    .brown_low  (brown_low),
    .brown_en   (brown_en),
    .pwrup_en_n (pwrup_en_n),
    .wake_req   (wake_req),
    .seq_state  (seq_state)
);

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
// Self-checking bench for pwrup_seq with a small configuration.
module test_pwrup_seq;

    localparam int PB = 4;
    localparam int XC = 8;
    localparam int LT = 5;
    localparam int BF = 4;
    localparam int PWRUP_LEN = 1 << PB;

    logic       clk = 1'b0;
    logic       rst_n, por_pulse, brown_low, rc_tick, osc_tick;
    logic [2:0] osc_mode;
    logic       pwrup_en_n, brown_en, wake_req;
    logic       dev_reset, seq_done;
    logic [2:0] seq_state;

    int rc_div = 1, osc_div = 1, rc_ph = 0, osc_ph = 0;
    int n_pwrup = 0, n_xtal = 0, n_lock = 0;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pwrup_seq #(
        .PWRUP_BITS(PB), .XTAL_CYCLES(XC), .LOCK_TICKS(LT), .BROWN_FILTER(BF)
    ) i_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .brown_low(brown_low),
        .rc_tick(rc_tick), .osc_tick(osc_tick), .osc_mode(osc_mode),
        .pwrup_en_n(pwrup_en_n), .brown_en(brown_en), .wake_req(wake_req),
        .dev_reset(dev_reset), .seq_state(seq_state), .seq_done(seq_done)
    );

    // Tick generators, updated 1 ns after each rising edge.
    initial begin
        rc_tick = 1'b0;
        osc_tick = 1'b0;
        forever begin
            @(posedge clk); #1;
            rc_tick  = (rc_ph == 0);
            osc_tick = (osc_ph == 0);
            rc_ph  = (rc_ph + 1 >= rc_div) ? 0 : rc_ph + 1;
            osc_ph = (osc_ph + 1 >= osc_div) ? 0 : osc_ph + 1;
        end
    end

    // Count the ticks consumed in each wait; cleared in IDLE and brown-out hold.
    initial begin
        forever begin
            @(negedge clk);
            if (seq_state == 3'd0 || seq_state == 3'd4) begin
                n_pwrup = 0; n_xtal = 0; n_lock = 0;
            end else begin
                if (seq_state == 3'd1 && rc_tick)  n_pwrup++;
                if (seq_state == 3'd2 && osc_tick) n_xtal++;
                if (seq_state == 3'd3 && rc_tick)  n_lock++;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_to_run(input string what);
        int k = 0;
        while (!seq_done && k < 5000) begin
            step();
            k++;
        end
        chk(int'(seq_done), 1, what);
    endtask

    task automatic por_start();
        por_pulse = 1'b1;
        step();
        chk(int'(seq_state), 0, "R1 power-on pulse gives IDLE");
        por_pulse = 1'b0;
    endtask

    // Hold the flag for 'len' cycles (one RC tick per cycle at rc_div=1).
    task automatic dip(input int len);
        brown_low = 1'b1;
        repeat (len) step();
    endtask

    initial begin
        rst_n = 1'b0; por_pulse = 1'b0; brown_low = 1'b0; osc_mode = 3'd5;
        pwrup_en_n = 1'b0; brown_en = 1'b0; wake_req = 1'b0;
        repeat (3) step();
        chk(int'(seq_state), 0, "R1 reset state code");
        chk(int'(dev_reset), 1, "R2 reset held in IDLE");
        chk(int'(seq_done), 0, "R2 done low in IDLE");
        rst_n = 1'b1;

        // Sweep of modes, power-up enable and tick rates.
        for (int m = 0; m < 8; m++) begin
            for (int pen = 0; pen < 2; pen++) begin
                for (int dv = 1; dv <= 2; dv++) begin
                    osc_mode = 3'(m); pwrup_en_n = pen[0];
                    rc_div = dv; osc_div = dv + 1;
                    por_start();
                    run_to_run("R2 RUN reached after power-on");
                    chk(n_pwrup, (pen == 0) ? PWRUP_LEN : 0, $sformatf("R3 power-up ticks mode %0d", m));
                    chk(n_xtal, (m < 4) ? XC : 0, $sformatf("R4 crystal cycles mode %0d", m));
                    chk(n_lock, (m == 3) ? LT : 0, $sformatf("R5 lock ticks mode %0d", m));
                    chk(int'(dev_reset), 0, "R2 reset released in RUN");
                    chk(int'(seq_state), 5, "R2 RUN code");
                end
            end
        end

        // Power-on pulse in the middle of the crystal wait.
        rc_div = 1; osc_div = 3; osc_mode = 3'd1; pwrup_en_n = 1'b1;
        por_start();
        for (int k = 0; k < 100 && seq_state != 3'd2; k++) step();
        repeat (3) step();
        chk(int'(seq_state), 2, "R4 in crystal wait before pulse");
        por_pulse = 1'b1;
        step();
        chk(int'(seq_state), 0, "R1 pulse pre-empts crystal wait");
        por_pulse = 1'b0;
        run_to_run("R1 rerun after pulse");
        chk(n_xtal, XC, "R1 full crystal wait after pulse");

        // Wake requests.
        osc_div = 1;
        n_pwrup = 0; n_xtal = 0; n_lock = 0;
        wake_req = 1'b1; step(); wake_req = 1'b0;
        chk(int'(seq_state), 2, "R6 wake enters crystal wait");
        run_to_run("R6 RUN after wake");
        chk(n_xtal, XC, "R6 crystal cycles after wake");
        osc_mode = 3'd3;
        n_pwrup = 0; n_xtal = 0; n_lock = 0;
        wake_req = 1'b1; step(); wake_req = 1'b0;
        run_to_run("R6 RUN after wake mode 3");
        chk(n_xtal, XC, "R6 crystal cycles mode 3");
        chk(n_lock, LT, "R6 lock ticks after wake mode 3");
        osc_mode = 3'd6;
        wake_req = 1'b1; step(); wake_req = 1'b0;
        step();
        chk(int'(seq_state), 5, "R6 wake ignored in non-crystal mode");

        // Brown-out disabled.
        brown_en = 1'b0;
        dip(20);
        chk(int'(seq_state), 5, "R8 flag ignored when disabled");
        brown_low = 1'b0;
        step();

        // Filter edge.
        brown_en = 1'b1; osc_mode = 3'd1; pwrup_en_n = 1'b0;
        dip(BF);
        brown_low = 1'b0;
        step();
        chk(int'(seq_state), 5, "R7 dip of filter length ignored");
        repeat (3) step();
        chk(int'(seq_state), 5, "R7 still running after dip");
        dip(BF + 1);
        chk(int'(seq_state), 4, "R7 dip past filter trips");
        begin
            int held = 1;
            for (int k = 0; k < 20; k++) begin
                step();
                if (seq_state != 3'd4 || !dev_reset) held = 0;
            end
            chk(held, 1, "R9 hold while flag stays low");
        end
        brown_low = 1'b0;
        step();
        chk(int'(seq_state), 1, "R10 exit enters power-up wait");
        run_to_run("R10 RUN after hold");
        chk(n_pwrup, PWRUP_LEN, "R10 full power-up wait after hold");
        chk(n_xtal, 0, "R10 crystal wait skipped after hold");

        // Flag returns during the power-up wait.
        dip(BF + 1);
        brown_low = 1'b0;
        step();
        repeat (6) step();
        chk(int'(seq_state), 1, "R11 mid power-up wait");
        brown_low = 1'b1;
        step();
        chk(int'(seq_state), 4, "R11 flag aborts power-up wait");
        brown_low = 1'b0;
        step();
        run_to_run("R11 RUN after restart");
        chk(n_pwrup, PWRUP_LEN, "R11 count restarted in full");

        // Exit with the power-up wait disabled.
        pwrup_en_n = 1'b1;
        dip(BF + 1);
        chk(int'(seq_state), 4, "R12 hold entered");
        brown_low = 1'b0;
        step();
        chk(int'(seq_state), 5, "R12 direct exit to RUN");

        summary();
        $finish;
    end

endmodule